// File: doc/BRIEF.md
# MDIO Management Master

This block drives the two-wire management bus of Ethernet PHYs (IEEE 802.3 Clause 22 frames). Software sets up the management clock and turns the bus on through a control register. It then starts single register accesses by writing one 32-bit access word. The block clocks out a full frame on MDC and MDIO. On a read it lets go of the data line for the turnaround and shifts in the PHY's reply. When the frame is done it clears the GO bit in the access word, and it reports the acknowledge result and any returned data in that same word.

A liveness bitmap gives one bit to each of the 32 PHY addresses. A bit is set whenever a read at that address was acknowledged. An optional fault flag records reads that no PHY acknowledged. The register bus is a plain write strobe with a word address, and read data is available combinationally. The MDIO pin is split into an output, an output enable and an input, and the line is expected to have a pull-up.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the control word reads 0x8000_0000 (idle, disabled, divider 0), the liveness bitmap and the access word read 0, MDC is low and the MDIO output enable is low.
- R2: Control word (address 0): bits 7:0 divider, bit 18 fault-enable, bit 19 fault flag (write 1 to clear), bit 30 bus enable, bit 31 read-only IDLE, which is 1 exactly when no access is in progress.
- R3: While enabled, MDC has a period of divider+1 clock cycles, and a divider of 0 acts as 1 (period 2); while disabled MDC stays low.
- R4: Access word (address 2): bit 31 GO, bit 30 WRITE (1 = write, 0 = read), bit 29 ACK, bits 25:21 register, bits 20:16 PHY address, bits 15:0 data. Writing it with GO set while enabled and idle starts an access, and GO reads 1 until the access ends.
- R5: A write access sends 32 preamble ones, start 01, opcode 01, PHY address, register, turnaround 10 and 16 data bits MSB first, so the addressed PHY stores the data. The access word keeps the written data and ACK reads 0 afterwards.
- R6: A read access sends opcode 10. When it ends, ACK is 1 if the line was low in the second turnaround bit, and bits 15:0 hold the 16 bits sampled afterwards. With no PHY answering, ACK is 0 and the data reads 0xFFFF.
- R7: MDIO output and output enable change only on MDC falling edges, and on a read the output enable stays low from the first turnaround bit to the end of the frame.
- R8: A write to the access word while GO is 1 is ignored: the running access and every field of the word are unaffected.
- R9: Writing the access word with GO set while the bus is disabled stores the other fields but leaves GO at 0 and starts nothing.
- R10: A liveness bit (address 1, bit n for PHY address n) is set when a read at address n ends with ACK 1. It is cleared only by reset, and writes to address 1 are ignored.
- R11: When fault-enable is set, a read that ends with ACK 0 sets the fault flag. Writing 1 to bit 19 clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address: 0 control, 1 liveness, 2 access |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe_o | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | MDIO line as seen at the pin |

## Verification
A wrong bit counter or frame build shows up at the PHY side within one frame: the PHY either fails to decode the frame or stores a wrong value, and the next read of that register returns the wrong data or ACK. A wrong sampling point shifts the read data by one bit or flips ACK as soon as the first read completes. A stuck GO or a broken busy lock shows up on the next poll of the access word, which either never clears or shows fields that a blocked write changed. Divider faults show up within two MDC periods as a wrong edge spacing.

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int BW        = $clog2(FRAME_LEN + 1);
  localparam int TA_POS    = PRE_LEN + 14;
  localparam logic [1:0] A_CTRL = 2'd0, A_ALIVE = 2'd1, A_UA = 2'd2;

  logic [DIV_W-1:0] div_q, cnt_q;
  logic             en_q, fen_q, flt_q;
  logic             go_q, wr_q, ack_q, ack_r;
  logic [4:0]       ra_q, pa_q;
  logic [15:0]      dat_q;
  logic [31:0]      alive_q;
  logic             started_q;
  logic [BW-1:0]    bit_q;
  logic             mdc_q, mo_q, oe_q;

  wire [DIV_W-1:0] top_w  = (div_q == '0) ? DIV_W'(1) : div_q;
  wire [DIV_W:0]   per_w  = {1'b0, top_w} + 1'b1;
  wire [DIV_W-1:0] half_w = per_w[DIV_W:1];
  wire             wrap_w = cnt_q >= top_w;
  wire [DIV_W-1:0] cnt_nx = wrap_w ? '0 : cnt_q + 1'b1;
  wire             fall_t = en_q && wrap_w;
  wire             rise_t = en_q && (cnt_nx == half_w);

  wire          ua_we = reg_we_i && (reg_addr_i == A_UA);
  wire          last  = started_q && (bit_q == BW'(FRAME_LEN - 1));
  wire [BW-1:0] nb_w  = started_q ? bit_q + 1'b1 : '0;
  wire [BW-1:0] hidx  = BW'(FRAME_LEN - 1) - nb_w;
  wire [31:0]   hdr   = {2'b01, wr_q ? 2'b01 : 2'b10, pa_q, ra_q,
                         wr_q ? 2'b10 : 2'b11, wr_q ? dat_q : 16'hFFFF};
  wire          fbit  = (nb_w < BW'(PRE_LEN)) ? 1'b1 : hdr[hidx[4:0]];
  wire          obit  = wr_q || (nb_w < BW'(TA_POS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0; cnt_q <= '0; en_q <= 1'b0; fen_q <= 1'b0; flt_q <= 1'b0;
      go_q <= 1'b0; wr_q <= 1'b0; ack_q <= 1'b0; ack_r <= 1'b0;
      ra_q <= '0; pa_q <= '0; dat_q <= '0; alive_q <= '0;
      started_q <= 1'b0; bit_q <= '0;
      mdc_q <= 1'b0; mo_q <= 1'b1; oe_q <= 1'b0;
    end else begin
      if (!en_q) begin
        cnt_q <= '0;
        mdc_q <= 1'b0;
      end else begin
        cnt_q <= cnt_nx;
        if (fall_t)      mdc_q <= 1'b0;
        else if (rise_t) mdc_q <= 1'b1;
      end

      if (reg_we_i && reg_addr_i == A_CTRL) begin
        div_q <= reg_wdata_i[DIV_W-1:0];
        fen_q <= reg_wdata_i[18];
        en_q  <= reg_wdata_i[30];
        if (reg_wdata_i[19]) flt_q <= 1'b0;
      end

      if (ua_we && !go_q) begin
        go_q  <= reg_wdata_i[31] && en_q;
        wr_q  <= reg_wdata_i[30];
        ack_q <= 1'b0;
        ra_q  <= reg_wdata_i[25:21];
        pa_q  <= reg_wdata_i[20:16];
        dat_q <= reg_wdata_i[15:0];
      end

      if (go_q && fall_t) begin
        if (last) begin
          go_q      <= 1'b0;
          started_q <= 1'b0;
          oe_q      <= 1'b0;
          mo_q      <= 1'b1;
          if (!wr_q) begin
            ack_q <= ack_r;
            if (ack_r)      alive_q[pa_q] <= 1'b1;
            else if (fen_q) flt_q <= 1'b1;
          end
        end else begin
          started_q <= 1'b1;
          bit_q     <= nb_w;
          mo_q      <= fbit;
          oe_q      <= obit;
        end
      end

      if (go_q && started_q && !wr_q && rise_t) begin
        if (bit_q == BW'(TA_POS + 1)) ack_r <= !mdio_i;
        if (bit_q >= BW'(TA_POS + 2)) dat_q <= {dat_q[14:0], mdio_i};
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[DIV_W-1:0] = div_q;
        reg_rdata_o[18] = fen_q;
        reg_rdata_o[19] = flt_q;
        reg_rdata_o[30] = en_q;
        reg_rdata_o[31] = !go_q;
      end
      A_ALIVE: reg_rdata_o = alive_q;
      A_UA:    reg_rdata_o = {go_q, wr_q, ack_q, 3'b000, ra_q, pa_q, dat_q};
      default: reg_rdata_o = '0;
    endcase
  end

  assign mdc_o     = mdc_q;
  assign mdio_o    = mo_q;
  assign mdio_oe_o = oe_q;

  // R8
  busy_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_q && ua_we) |=> (ra_q == $past(ra_q) && pa_q == $past(pa_q) && wr_q == $past(wr_q)));

  // R7
  ta_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_q && started_q && !wr_q && bit_q >= BW'(TA_POS)) |-> !mdio_oe_o);

  // R7
  fall_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(mdio_o) || !$stable(mdio_oe_o)) |-> $past(fall_t));

  // R10
  alive_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((alive_q & $past(alive_q)) == $past(alive_q)));

  // R3
  mdc_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !mdc_o);

  // R9
  go_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(go_q) |-> $past(en_q));
endmodule

// File: tb/mdio_mgmt_master_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc_w, mo_w, oe_w, line_w;
  logic        phy_en = 1'b0, phy_bit = 1'b1;

  int checks = 0, fails = 0;
  bit finished = 0;
  int mdc_rises = 0;

  always #5 clk = ~clk;

  mdio_mgmt_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mdc_o(mdc_w),
    .mdio_o(mo_w), .mdio_oe_o(oe_w), .mdio_i(line_w)
  );

  assign line_w = oe_w ? mo_w : (phy_en ? phy_bit : 1'b1);

  always @(posedge mdc_w) mdc_rises++;

  // behavioural PHY at address 5
  localparam logic [4:0] PHYA = 5'd5;
  logic [15:0] phy_regs [32];
  int st = 0, ones = 0, cnt = 0, rdk = 0;
  logic [11:0] hdr = '0;
  logic [17:0] wsh = '0;
  logic [4:0]  ra = '0;

  initial for (int i = 0; i < 32; i++) phy_regs[i] = 16'h1000 + 16'(i);

  always @(mdc_w) begin
    if (mdc_w) begin
      case (st)
        0: if (line_w) ones++;
           else if (ones >= 32) st = 1;
           else ones = 0;
        1: if (line_w) begin st = 2; cnt = 0; end
           else begin st = 0; ones = 0; end
        2: begin
          hdr = {hdr[10:0], line_w};
          cnt++;
          if (cnt == 12) begin
            ra = hdr[4:0];
            cnt = 0; rdk = 0; ones = 0;
            if (hdr[9:5] != PHYA) st = 0;
            else if (hdr[11:10] == 2'b10) st = 3;
            else if (hdr[11:10] == 2'b01) st = 4;
            else st = 0;
          end
        end
        4: begin
          wsh = {wsh[16:0], line_w};
          cnt++;
          if (cnt == 18) begin
            phy_regs[ra] = wsh[15:0];
            st = 0; ones = 0;
          end
        end
        default: ;
      endcase
    end else if (st == 3) begin
      rdk++;
      if (rdk == 2) begin phy_en = 1'b1; phy_bit = 1'b0; end
      else if (rdk >= 3 && rdk <= 18) phy_bit = phy_regs[ra][18-rdk];
      else if (rdk == 19) begin phy_en = 1'b0; phy_bit = 1'b1; st = 0; ones = 0; end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    v = 32'h8000_0000;
    while (v[31]) bus_rd(2'd2, v);
  endtask

  task automatic period(output int p);
    time t0;
    @(posedge mdc_w); @(posedge mdc_w); t0 = $time;
    @(posedge mdc_w); p = int'(($time - t0) / 10);
  endtask

  // {wr, phy, reg, wdata, exp_ack, exp_data}
  localparam int NV = 11;
  localparam logic [43:0] VEC [NV] = '{
    {1'b1, 5'd5, 5'd3,  16'hA5C3, 1'b0, 16'hA5C3},
    {1'b0, 5'd5, 5'd3,  16'h0000, 1'b1, 16'hA5C3},
    {1'b1, 5'd5, 5'd31, 16'h0001, 1'b0, 16'h0001},
    {1'b0, 5'd5, 5'd31, 16'h0000, 1'b1, 16'h0001},
    {1'b0, 5'd7, 5'd3,  16'h0000, 1'b0, 16'hFFFF},
    {1'b1, 5'd5, 5'd0,  16'hFFFF, 1'b0, 16'hFFFF},
    {1'b0, 5'd5, 5'd0,  16'h0000, 1'b1, 16'hFFFF},
    {1'b1, 5'd5, 5'd0,  16'h0000, 1'b0, 16'h0000},
    {1'b0, 5'd5, 5'd0,  16'h0000, 1'b1, 16'h0000},
    {1'b0, 5'd5, 5'd9,  16'h0000, 1'b1, 16'h1009},
    {1'b0, 5'd0, 5'd9,  16'h0000, 1'b0, 16'hFFFF}
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    logic [31:0] v, e;
    int p, r0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(2'd0, v); chk(v == 32'h8000_0000, "R1 ctrl", v, 32'h8000_0000);
    bus_rd(2'd1, v); chk(v == 32'h0, "R1 alive", v, 32'h0);
    bus_rd(2'd2, v); chk(v == 32'h0, "R1 access", v, 32'h0);
    chk(mdc_w == 1'b0 && oe_w == 1'b0, "R1 pins", {30'd0, mdc_w, oe_w}, 32'd0);

    // R9 GO while disabled
    r0 = mdc_rises;
    bus_wr(2'd2, 32'h8065_1234);
    bus_rd(2'd2, v); chk(v == 32'h0065_1234, "R9 word", v, 32'h0065_1234);
    repeat (40) @(negedge clk);
    chk(mdc_rises == r0, "R9 no mdc", mdc_rises, r0);

    // R2 / R3 control and divider
    bus_wr(2'd0, 32'h4000_0003);
    bus_rd(2'd0, v); chk(v == 32'hC000_0003, "R2 ctrl readback", v, 32'hC000_0003);
    period(p); chk(p == 4, "R3 div3", p, 4);
    bus_wr(2'd0, 32'h4000_0004);
    period(p); chk(p == 5, "R3 div4", p, 5);
    bus_wr(2'd0, 32'h4000_0000);
    period(p); chk(p == 2, "R3 div0", p, 2);
    bus_wr(2'd0, 32'h4000_0002);
    period(p); chk(p == 3, "R3 div2", p, 3);

    // R4 R5 R6 table of accesses
    for (int k = 0; k < NV; k++) begin
      logic [43:0] t;
      t = VEC[k];
      bus_wr(2'd2, {1'b1, t[43], 4'b0000, t[37:33], t[42:38], t[32:17]});
      bus_rd(2'd0, v); chk(v[31] == 1'b0, "R2 idle low while busy", v, 32'h4000_0002);
      bus_rd(2'd2, v); chk(v[31] == 1'b1, "R4 GO held", v, 32'h8000_0000);
      wait_idle();
      e = {1'b0, t[43], t[16], 3'b000, t[37:33], t[42:38], t[15:0]};
      bus_rd(2'd2, v);
      chk(v == e, t[43] ? "R5 write access" : "R6 read access", v, e);
    end

    // R10 liveness
    bus_rd(2'd1, v); chk(v == 32'h0000_0020, "R10 alive", v, 32'h20);
    bus_wr(2'd1, 32'h0);
    bus_rd(2'd1, v); chk(v == 32'h0000_0020, "R10 alive write ignored", v, 32'h20);

    // R11 fault flag
    bus_wr(2'd0, 32'h4004_0002);
    bus_wr(2'd2, 32'h8067_0000);
    wait_idle();
    bus_rd(2'd0, v); chk(v == 32'hC00C_0002, "R11 fault set", v, 32'hC00C_0002);
    bus_wr(2'd0, 32'h400C_0002);
    bus_rd(2'd0, v); chk(v == 32'hC004_0002, "R11 fault cleared", v, 32'hC004_0002);

    // R8 write while busy
    bus_wr(2'd2, 32'h8065_0000);
    repeat (10) @(negedge clk);
    bus_wr(2'd2, 32'hC0E5_0BAD);
    wait_idle();
    bus_rd(2'd2, v); chk(v == 32'h2065_A5C3, "R8 busy write ignored", v, 32'h2065_A5C3);
    bus_wr(2'd2, 32'h80E5_0000);
    wait_idle();
    bus_rd(2'd2, v); chk(v == 32'h20E5_1007, "R8 reg7 untouched", v, 32'h20E5_1007);

    summary();
  end
endmodule